// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns an asynchronous serial input line into parallel characters for a host. A single-cycle enable, `sample_tick`, is the oversampling clock. A rate code sets how many ticks make up one bit time: 1, 16 or 64. When the rate is 16 or 64, a falling edge on the line is only accepted as a start bit after the line is checked again half a bit later. The word length (5 to 8 bits), parity enable and parity sense are programmed through configuration inputs. The receiver captures these settings at each start bit, so the host can change them at run time without corrupting a character that is already arriving.

Each finished character goes into a holding register and raises a ready flag. A host read strobe lowers the ready flag. Four error indications sit alongside the character:

- parity mismatch
- missing stop bit
- overrun, where a new character lands on one that has not been read
- line break, where the whole frame is zero

These four flags are sticky. Reading the character does not clear them. Only an error-clear command clears them. A receive-enable input gates all reception.

Top module: `serial_rx_core`

## Requirements
- R1: After the last bit of a frame is sampled, `char_ready` rises and `rd_data` holds the character. Data arrives least-significant bit first, and `rd_data` bits above the word length read as 0.
- R2: `cfg_wlen` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_even`=1 the data plus parity bit must hold an even number of ones; with 0 they must hold an odd number. A mismatch sets `err_parity`.
- R4: Only the first stop bit is examined. If it is sampled as 0, `err_frame` is set. A new start bit may follow that first stop bit directly.
- R5: If every sampled bit of a frame is 0, `brk_detect` is set together with `err_frame`. This covers the start bit, the data bits, the parity bit if enabled, and the one stop bit.
- R6: If a frame completes while `char_ready` is still 1 and no read happens in that cycle, `err_overrun` is set. `rd_data` then holds the newer character, and the older one is lost.
- R7: `err_parity`, `err_frame`, `err_overrun` and `brk_detect` stay set through host reads and later good characters. A one-cycle `err_clear`=1 clears them.
- R8: A one-cycle `host_rd`=1 clears `char_ready` if no frame completes in that cycle.
- R9: While `rx_enable`=0 nothing is received. A frame already in progress is dropped and is not delivered when reception is enabled again.
- R10: `cfg_rate` selects the bit time: 00 or 01 gives 1 tick, 10 gives 16 ticks, 11 gives 64 ticks. At 16 or 64 ticks, a low pulse that has ended by the mid-bit recheck is ignored.
- R11: Word length and parity settings are taken at the start bit. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle oversampling tick |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_rate | input | 2 | Ticks per bit code |
| cfg_wlen | input | 2 | Data length code (5 + value) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even, 0 odd parity |
| rx_enable | input | 1 | Reception allowed |
| err_clear | input | 1 | Clear all sticky error flags |
| host_rd | input | 1 | Host has read the character |
| rd_data | output | 8 | Received character |
| char_ready | output | 1 | Unread character present |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |
| brk_detect | output | 1 | Sticky break detected |

## Verification
The bench targets these corner cases:

- **Short low pulse at 16x.** A receiver that skips the mid-bit recheck would deliver a spurious character.
- **All-zero frame with parity.** If the parity bit were left out of the zero test, or the break were reported without a framing error, the flags would come out wrong.
- **Two frames back to back with a single stop bit.** A receiver that waits for the programmed stop count would lose the second start bit.
- **Overrun with no read in between.** The newest character must survive and the overrun flag must be set.
- **Sticky flags under reads and good frames.** Clearing a flag on a read would be caught.
- **Word length changed mid-frame.** Truncated data or a false framing error would show if the settings were not captured at the start bit.
- **Enable dropped mid-frame.** The dropped frame must never surface as a character.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int MAX_DATA   = 8;
    localparam int MIN_DATA   = 5;
    localparam int TICK_W     = 6;
    localparam int POS_W      = 4;
    localparam int IDX_W      = $clog2(MAX_DATA);
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        RATE_X1_ALT = 2'b00,
        RATE_X1     = 2'b01,
        RATE_X16    = 2'b10,
        RATE_X64    = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        SMP_IDLE   = 2'd0,
        SMP_VERIFY = 2'd1,
        SMP_RUN    = 2'd2
    } smp_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_even;
    } fmt_t;

    typedef struct packed {
        logic [MAX_DATA-1:0] data;
        logic                par_err;
        logic                frm_err;
        logic                brk;
    } frame_res_t;

    function automatic logic [TICK_W:0] ticks_per_bit(input rate_e r);
        case (r)
            RATE_X16: return (TICK_W+1)'(16);
            RATE_X64: return (TICK_W+1)'(64);
            default:  return (TICK_W+1)'(1);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] data_bits(input logic [1:0] wlen);
        return POS_W'(MIN_DATA) + POS_W'(wlen);
    endfunction

    function automatic logic [POS_W-1:0] stop_index(input fmt_t f);
        return data_bits(f.wlen) + POS_W'(f.par_en) + POS_W'(1);
    endfunction

endpackage

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rx_enable,
    input  logic  sample_tick,
    input  logic  rx_in,
    input  rate_e rate,
    input  logic  frame_end,
    output logic  bit_stb,
    output logic  bit_val,
    output logic  bit_first
);

    localparam int CNT_W = TICK_W;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    smp_state_e             state;
    logic [CNT_W-1:0]       cnt;
    logic [CNT_W:0]         per;
    logic                   single;

    assign rx_s   = sync_q[SYNC_STAGES-1];
    assign per    = ticks_per_bit(rate);
    assign single = (per == (CNT_W+1)'(1));

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_enable) begin
            state     <= SMP_IDLE;
            cnt       <= '0;
            bit_stb   <= 1'b0;
            bit_val   <= 1'b1;
            bit_first <= 1'b0;
        end else begin
            bit_stb   <= 1'b0;
            bit_first <= 1'b0;
            if (frame_end) begin
                state <= SMP_IDLE;
                cnt   <= '0;
            end else if (sample_tick) begin
                case (state)
                    SMP_IDLE: begin
                        if (!rx_s) begin
                            if (single) begin
                                bit_stb   <= 1'b1;
                                bit_val   <= 1'b0;
                                bit_first <= 1'b1;
                                cnt       <= '0;
                                state     <= SMP_RUN;
                            end else begin
                                cnt   <= CNT_W'((per >> 1) - 1);
                                state <= SMP_VERIFY;
                            end
                        end
                    end
                    SMP_VERIFY: begin
                        if (cnt == '0) begin
                            if (!rx_s) begin
                                bit_stb   <= 1'b1;
                                bit_val   <= 1'b0;
                                bit_first <= 1'b1;
                                cnt       <= CNT_W'(per - 1);
                                state     <= SMP_RUN;
                            end else begin
                                state <= SMP_IDLE;
                            end
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    SMP_RUN: begin
                        if (cnt == '0) begin
                            bit_stb <= 1'b1;
                            bit_val <= rx_s;
                            cnt     <= CNT_W'(per - 1);
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    default: state <= SMP_IDLE;
                endcase
            end
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> (state == SMP_IDLE && !bit_stb)) else $error("sampler active while disabled"); // R9

    AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (rx_enable && state == SMP_VERIFY && sample_tick && cnt == '0 && rx_s)
        |=> (state == SMP_IDLE && !bit_stb)) else $error("glitch accepted as start"); // R10

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_enable,
    input  logic       bit_stb,
    input  logic       bit_val,
    input  logic       bit_first,
    input  fmt_t       fmt_in,
    output logic       done,
    output frame_res_t res
);

    fmt_t                fmt_q;
    logic [POS_W-1:0]    pos;
    logic [MAX_DATA-1:0] shreg;
    logic                par_acc;
    logic                any_one;
    logic [POS_W-1:0]    nbits;
    logic [POS_W-1:0]    stop_pos;
    logic [IDX_W-1:0]    idx;
    logic                in_data;
    logic                is_par;
    logic                at_stop;

    always_comb begin
        nbits    = data_bits(fmt_q.wlen);
        stop_pos = stop_index(fmt_q);
        idx      = IDX_W'(pos - POS_W'(1));
        in_data  = (pos != '0) && (pos <= nbits);
        is_par   = fmt_q.par_en && (pos == nbits + POS_W'(1));
        at_stop  = (pos == stop_pos);
    end

    assign done        = bit_stb && !bit_first && at_stop;
    assign res.data    = shreg;
    assign res.par_err = fmt_q.par_en && (par_acc == fmt_q.par_even);
    assign res.frm_err = !bit_val;
    assign res.brk     = !any_one && !bit_val;

    always_ff @(posedge clk) begin
        if (rst || !rx_enable) begin
            fmt_q   <= '0;
            pos     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            any_one <= 1'b0;
        end else if (bit_stb) begin
            if (bit_first) begin
                fmt_q   <= fmt_in;
                pos     <= POS_W'(1);
                shreg   <= '0;
                par_acc <= 1'b0;
                any_one <= 1'b0;
            end else if (at_stop) begin
                pos <= '0;
            end else begin
                pos     <= pos + POS_W'(1);
                any_one <= any_one | bit_val;
                if (in_data) begin
                    shreg[idx] <= bit_val;
                    par_acc    <= par_acc ^ bit_val;
                end else if (is_par) begin
                    par_acc <= par_acc ^ bit_val;
                end
            end
        end
    end

    AST_NO_ORPHAN_BIT: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !bit_first) |-> (pos != '0)) else $error("bit outside a frame"); // R1

    AST_NO_DONE_OFF: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !done) else $error("frame completed while disabled"); // R9

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import serial_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  frame_res_t          res,
    input  logic                host_rd,
    input  logic                err_clear,
    output logic [MAX_DATA-1:0] rd_data,
    output logic                char_ready,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_overrun,
    output logic                brk_detect
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            char_ready <= 1'b0;
        end else if (done) begin
            rd_data    <= res.data;
            char_ready <= 1'b1;
        end else if (host_rd) begin
            char_ready <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
            brk_detect  <= 1'b0;
        end else begin
            if (done && res.par_err)                err_parity  <= 1'b1;
            else if (err_clear)                     err_parity  <= 1'b0;
            if (done && res.frm_err)                err_frame   <= 1'b1;
            else if (err_clear)                     err_frame   <= 1'b0;
            if (done && char_ready && !host_rd)     err_overrun <= 1'b1;
            else if (err_clear)                     err_overrun <= 1'b0;
            if (done && res.brk)                    brk_detect  <= 1'b1;
            else if (err_clear)                     brk_detect  <= 1'b0;
        end
    end

    AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> char_ready) else $error("ready not raised"); // R1

    AST_BRK_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
        (done && res.brk) |=> (brk_detect && err_frame)) else $error("break without framing error"); // R5

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (done && char_ready && !host_rd) |=> err_overrun) else $error("overrun missed"); // R6

    AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_parity && !err_clear) |=> err_parity) else $error("parity flag dropped"); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_overrun && !err_clear) |=> err_overrun) else $error("overrun flag dropped"); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !done) |=> !char_ready) else $error("read did not clear ready"); // R8

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_tick,
    input  logic                rx_line,
    input  logic [1:0]          cfg_rate,
    input  logic [1:0]          cfg_wlen,
    input  logic                cfg_par_en,
    input  logic                cfg_par_even,
    input  logic                rx_enable,
    input  logic                err_clear,
    input  logic                host_rd,
    output logic [MAX_DATA-1:0] rd_data,
    output logic                char_ready,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_overrun,
    output logic                brk_detect
);

    logic       bit_stb;
    logic       bit_val;
    logic       bit_first;
    logic       done;
    frame_res_t res;
    fmt_t       fmt_now;

    assign fmt_now = '{wlen: cfg_wlen, par_en: cfg_par_en, par_even: cfg_par_even};

    serial_rx_sampler #(.SYNC_STAGES(SYNC_DEPTH)) u_sampler (
        .clk         (clk),
        .rst         (rst),
        .rx_enable   (rx_enable),
        .sample_tick (sample_tick),
        .rx_in       (rx_line),
        .rate        (rate_e'(cfg_rate)),
        .frame_end   (done),
        .bit_stb     (bit_stb),
        .bit_val     (bit_val),
        .bit_first   (bit_first)
    );

    serial_rx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .rx_enable (rx_enable),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .bit_first (bit_first),
        .fmt_in    (fmt_now),
        .done      (done),
        .res       (res)
    );

    serial_rx_status u_status (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .res         (res),
        .host_rd     (host_rd),
        .err_clear   (err_clear),
        .rd_data     (rd_data),
        .char_ready  (char_ready),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun),
        .brk_detect  (brk_detect)
    );

endmodule

// File: tb/serial_rx_core_tb.sv
`timescale 1ns/1ps
module serial_rx_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_rate = 2'b10;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       rx_enable = 1'b1;
    logic       err_clear;
    logic       host_rd;
    logic [7:0] rd_data;
    logic       char_ready, err_parity, err_frame, err_overrun, brk_detect;

    logic mon_rd = 1'b0, mon_clr = 1'b0, dir_rd = 1'b0, dir_clr = 1'b0;
    bit   mon_on = 1'b0;
    assign host_rd   = mon_rd | dir_rd;
    assign err_clear = mon_clr | dir_clr;

    always #2.5 clk = ~clk;

    logic [1:0] tdiv = 2'd0;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign sample_tick = (tdiv == 2'd3);

    serial_rx_core u_dut (
        .clk(clk), .rst(rst), .sample_tick(sample_tick), .rx_line(rx_line),
        .cfg_rate(cfg_rate), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .rx_enable(rx_enable), .err_clear(err_clear),
        .host_rd(host_rd), .rd_data(rd_data), .char_ready(char_ready),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
        .brk_detect(brk_detect)
    );

    int  n_chk = 0, n_err = 0;
    bit  ended = 0;
    int  per_now = 16, cur_nb = 8;
    bit  cur_pe = 0, cur_even = 0;

    typedef struct { logic [7:0] d; bit pe; bit fe; bit brk; } exp_t;
    exp_t sb_q[$];
    exp_t mon_e;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic set_cfg(input logic [1:0] rate, input logic [1:0] wl, input bit pe, input bit ev);
        cfg_rate = rate; cfg_wlen = wl; cfg_par_en = pe; cfg_par_even = ev;
        per_now  = (rate == 2'b10) ? 16 : (rate == 2'b11) ? 64 : 1;
        cur_nb = 5 + int'(wl); cur_pe = pe; cur_even = ev;
    endtask

    function automatic logic [7:0] low_mask(input int nb);
        return 8'((1 << nb) - 1);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input bit ev, input bit flip);
        return (^d) ^ ~ev ^ flip;
    endfunction

    task automatic hold(input int nbit);
        repeat (nbit * per_now * 4) @(negedge clk);
    endtask

    task automatic align();
        do @(negedge clk); while (!sample_tick);
        @(negedge clk);
    endtask

    task automatic drive_frame(input logic [7:0] d, input bit flip, input bit stop_v);
        logic [7:0] dm;
        dm = d & low_mask(cur_nb);
        align();
        rx_line = 1'b0; hold(1);
        for (int i = 0; i < cur_nb; i++) begin rx_line = dm[i]; hold(1); end
        if (cur_pe) begin rx_line = par_bit(dm, cur_even, flip); hold(1); end
        rx_line = stop_v; hold(1);
        rx_line = 1'b1;
    endtask

    task automatic sb_frame(input logic [7:0] d, input bit flip, input bit stop_v, input int gap);
        exp_t e;
        logic pb;
        e.d   = d & low_mask(cur_nb);
        pb    = cur_pe ? par_bit(e.d, cur_even, flip) : 1'b0;
        e.pe  = cur_pe && flip;
        e.fe  = !stop_v;
        e.brk = !stop_v && (e.d == 8'h00) && !pb;
        sb_q.push_back(e);
        drive_frame(d, flip, stop_v);
        hold(gap);
    endtask

    task automatic pulse_rd();
        @(negedge clk) dir_rd = 1'b1;
        @(negedge clk) dir_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) dir_clr = 1'b1;
        @(negedge clk) dir_clr = 1'b0;
    endtask

    // Monitor: pops the expected character as each one appears, then reads and clears
    always @(negedge clk) begin
        if (mon_rd) begin
            mon_rd  = 1'b0;
            mon_clr = 1'b0;
        end else if (mon_on && char_ready) begin
            if (sb_q.size() == 0) begin
                chk("R1 unexpected character", 32'd1, 32'd0);
            end else begin
                mon_e = sb_q.pop_front();
                chk("R1 R2 data", {24'd0, rd_data}, {24'd0, mon_e.d});
                chk("R3 parity flag", {31'd0, err_parity}, {31'd0, mon_e.pe});
                chk("R4 frame flag", {31'd0, err_frame}, {31'd0, mon_e.fe});
                chk("R5 break flag", {31'd0, brk_detect}, {31'd0, mon_e.brk});
                chk("R6 no overrun", {31'd0, err_overrun}, 32'd0);
            end
            mon_rd  = 1'b1;
            mon_clr = 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_err++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset ready", {31'd0, char_ready}, 32'd0);
        chk("R7 reset flags", {28'd0, err_parity, err_frame, err_overrun, brk_detect}, 32'd0);

        // Scoreboard phase
        mon_on = 1;
        set_cfg(2'b10, 2'b11, 0, 0);
        sb_frame(8'hA5, 0, 1, 3);                      // R1 R2 8-bit, 16x
        sb_frame(8'h3C, 0, 1, 3);
        set_cfg(2'b01, 2'b10, 1, 1);                   // R10 1x, R3 even parity, 7-bit
        sb_frame(8'h55, 0, 1, 3);
        sb_frame(8'h2B, 1, 1, 3);
        set_cfg(2'b00, 2'b00, 1, 0);                   // R3 odd parity, 5-bit
        sb_frame(8'h13, 0, 1, 3);
        sb_frame(8'hFF, 1, 1, 3);                      // upper bits must read 0
        set_cfg(2'b11, 2'b01, 0, 0);                   // R10 64x, 6-bit
        sb_frame(8'h2A, 0, 1, 3);
        sb_frame(8'h21, 0, 0, 3);                      // R4 stop bit low
        set_cfg(2'b10, 2'b11, 1, 1);
        sb_frame(8'h00, 0, 0, 3);                      // R5 break with parity bit
        set_cfg(2'b10, 2'b00, 0, 0);
        sb_frame(8'h00, 0, 0, 3);                      // R5 break 5-bit
        set_cfg(2'b10, 2'b11, 0, 0);
        sb_frame(8'h81, 0, 1, 0);                      // R4 back-to-back, single stop
        sb_frame(8'h7E, 0, 1, 3);
        chk("R1 all characters delivered", sb_q.size(), 32'd0);
        mon_on = 0;
        repeat (4) @(negedge clk);

        // R6 overrun: two frames, no read between
        drive_frame(8'h11, 0, 1); hold(2);
        drive_frame(8'h22, 0, 1); hold(2);
        chk("R6 ready after overrun", {31'd0, char_ready}, 32'd1);
        chk("R6 newest kept", {24'd0, rd_data}, 32'h22);
        chk("R6 overrun flag", {31'd0, err_overrun}, 32'd1);
        pulse_rd();
        chk("R8 read clears ready", {31'd0, char_ready}, 32'd0);
        chk("R7 overrun sticky after read", {31'd0, err_overrun}, 32'd1);
        pulse_clr();
        chk("R7 clear drops overrun", {31'd0, err_overrun}, 32'd0);

        // R7 parity flag stays through a good frame
        set_cfg(2'b10, 2'b11, 1, 1);
        drive_frame(8'h01, 1, 1); hold(2);
        chk("R3 parity error set", {31'd0, err_parity}, 32'd1);
        pulse_rd();
        drive_frame(8'h02, 0, 1); hold(2);
        chk("R7 parity sticky", {31'd0, err_parity}, 32'd1);
        chk("R7 good data", {24'd0, rd_data}, 32'h02);
        pulse_clr();
        chk("R7 parity cleared", {31'd0, err_parity}, 32'd0);
        pulse_rd();

        // R10 glitch at 16x
        set_cfg(2'b10, 2'b11, 0, 0);
        align();
        rx_line = 1'b0; repeat (8) @(negedge clk); rx_line = 1'b1;
        hold(12);
        chk("R10 glitch ignored", {31'd0, char_ready}, 32'd0);
        drive_frame(8'h5A, 0, 1); hold(2);
        chk("R10 frame after glitch", {23'd0, char_ready, rd_data}, {23'd0, 1'b1, 8'h5A});
        pulse_rd();

        // R9 disabled: no reception
        rx_enable = 1'b0;
        drive_frame(8'h77, 0, 1); hold(2);
        chk("R9 nothing while disabled", {31'd0, char_ready}, 32'd0);
        rx_enable = 1'b1;
        repeat (4) @(negedge clk);
        // R9 frame dropped mid-way
        align();
        rx_line = 1'b0; hold(1);
        rx_line = 1'b1; hold(2);
        rx_enable = 1'b0; repeat (10) @(negedge clk); rx_enable = 1'b1;
        hold(8);
        chk("R9 aborted frame dropped", {30'd0, char_ready, err_frame}, 32'd0);
        drive_frame(8'h66, 0, 1); hold(2);
        chk("R9 receive after re-enable", {23'd0, char_ready, rd_data}, {23'd0, 1'b1, 8'h66});
        pulse_rd();

        // R11 format change mid-frame
        fork
            drive_frame(8'hC3, 0, 1);
            begin repeat (3 * 64) @(negedge clk); cfg_wlen = 2'b00; cfg_par_en = 1'b1; end
        join
        hold(2);
        chk("R11 data unchanged", {24'd0, rd_data}, 32'hC3);
        chk("R11 no false errors", {29'd0, err_parity, err_frame, char_ready}, 32'd1);
        pulse_rd();

        finish_run();
    end

endmodule